// File: doc/BRIEF.md
# Phase Sweep Window Calibrator

This block calibrates the phase of a resynchronization clock against the memory clock. After a start pulse it takes one read test at every phase position of a full sweep. Between positions it asks an external clock generator to advance the phase by one step. The sweep has `STEPS_FULL` steps in full-rate mode and twice that many in half-rate mode. The result of each test goes into a pass map. When the sweep ends, the map is searched for one contiguous run of passing positions. A run that wraps from the last position back to position 0 counts as one run.

If exactly one run exists, the block picks its centre. It then advances the clock generator further, wrapping modulo the step count, until the clock sits at that centre. One more read test there measures the read latency. If no position passes, or if the passing positions form two or more separate runs, calibration fails and the latency output stays 0. Status is held until the next accepted start.

Top module: `phase_window_cal`

## Requirements
- R1: While reset is held and after it is released, `cal_ok`, `cal_fail`, `no_window`, `centre_ph`, `read_lat`, `step_req` and `rd_req` are all 0. `step_sel` always carries the parameter `PLL_CNT_SEL`, which is 3 bits wide.
- R2: A sweep takes one read test at each of N positions, where N is `STEPS_FULL` when `half_rate` is 0 and 2*`STEPS_FULL` when it is 1. Between positions there are N-1 phase steps. Each request is held until its acknowledge (`step_ack`) or completion (`rd_done`) arrives. A read is never requested while a step is pending.
- R3: When exactly one run of passing positions exists, the run starts at position s and has length L. Then `cal_ok` becomes 1 and `centre_ph` = (s + floor((L-1)/2)) mod N. An even-length run therefore rounds down.
- R4: A passing run that covers position N-1 and position 0 is one window. Its start s is its first position before the wrap. When all N positions pass, s = 0 and L = N.
- R5: On success, after the sweep the block issues (centre_ph + 1) mod N further steps. This leaves the generator at `centre_ph`. It then issues one more read, and `read_lat` takes the `rd_lat` value returned by that read.
- R6: When no position passes, `cal_fail` = 1, `no_window` = 1, and `centre_ph` and `read_lat` are 0.
- R7: When two or more separate passing runs exist, `cal_fail` = 1, while `no_window`, `centre_ph` and `read_lat` are 0.
- R8: `cal_ok` and `cal_fail` are never 1 together. Once set, the status outputs hold their values until the next accepted start.
- R9: A `start` seen while idle clears every status output on the next cycle and begins a new sweep at position 0. A `start` arriving while a sweep or park is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (accepted only while idle) |
| half_rate | input | 1 | Sampled at start; 1 doubles the sweep length |
| step_req | output | 1 | Phase-step request to the clock generator |
| step_sel | output | 3 | Which generator output is stepped |
| step_ack | input | 1 | Step completed |
| rd_req | output | 1 | Read-test request to the datapath |
| rd_done | input | 1 | Read test completed |
| rd_pass | input | 1 | Read returned correct data (valid with rd_done) |
| rd_lat | input | LAT_W | Measured read latency in clk cycles (valid with rd_done) |
| cal_ok | output | 1 | Calibration succeeded |
| cal_fail | output | 1 | Calibration failed |
| no_window | output | 1 | Failure because no position passed |
| centre_ph | output | log2(2*STEPS_FULL) | Centre phase, in steps from phase 0 |
| read_lat | output | LAT_W | Latency captured at the centre phase |

## Verification
Two events can land in the same cycle: a new `start` and the completion of a read or step handshake. The hardest case is the completing `rd_done` of the final latency read, which is also the edge where status is written. The bench drives `start` high together with every `rd_done` of one sweep, including that final one. It then checks three things: the read count still equals N+1, the status belongs to the original sweep, and no new request appears in the cycles that follow.

// File: rtl/phase_window_cal.sv
module phase_window_cal #(
  parameter int STEPS_FULL = 8,
  parameter int LAT_W = 4,
  parameter logic [2:0] PLL_CNT_SEL = 3'd4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_rate,
  output logic step_req,
  output logic [2:0] step_sel,
  input  logic step_ack,
  output logic rd_req,
  input  logic rd_done,
  input  logic rd_pass,
  input  logic [LAT_W-1:0] rd_lat,
  output logic cal_ok,
  output logic cal_fail,
  output logic no_window,
  output logic [$clog2(2*STEPS_FULL)-1:0] centre_ph,
  output logic [LAT_W-1:0] read_lat
);
  localparam int MAXN = 2 * STEPS_FULL;
  localparam int IDX_W = $clog2(MAXN);
  localparam int N_W = IDX_W + 1;
  localparam int SUM_W = N_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_STEP, S_EVAL, S_PARK, S_LAT} state_t;
  state_t state;

  logic [N_W-1:0]   n_steps;
  logic [IDX_W-1:0] pos;
  logic [MAXN-1:0]  pass_map;
  logic [N_W-1:0]   left;

  logic [IDX_W-1:0] last_idx;
  logic [N_W-1:0]   pop, runs, half_len, park;
  logic [IDX_W-1:0] wstart, ctr, prev;
  logic [SUM_W-1:0] mid;
  logic             single;

  assign step_sel = PLL_CNT_SEL;
  assign step_req = (state == S_STEP) || (state == S_PARK);
  assign rd_req   = (state == S_READ) || (state == S_LAT);
  assign last_idx = IDX_W'(n_steps - 1'b1);

  always_comb begin
    pop = '0;
    runs = '0;
    wstart = '0;
    prev = '0;
    for (int i = 0; i < MAXN; i++) begin
      if (N_W'(i) < n_steps) begin
        prev = (i == 0) ? last_idx : IDX_W'(i - 1);
        if (pass_map[i]) pop = pop + 1'b1;
        if (pass_map[i] && !pass_map[prev]) begin
          runs = runs + 1'b1;
          wstart = IDX_W'(i);
        end
      end
    end
  end

  assign single   = (pop == n_steps) || (pop != '0 && runs == N_W'(1));
  assign half_len = (pop - 1'b1) >> 1;
  assign mid      = SUM_W'(wstart) + SUM_W'(half_len);
  assign ctr      = (mid >= SUM_W'(n_steps)) ? IDX_W'(mid - SUM_W'(n_steps)) : IDX_W'(mid);
  assign park     = (ctr == last_idx) ? '0 : N_W'(ctr) + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      n_steps <= N_W'(STEPS_FULL);
      pos <= '0;
      pass_map <= '0;
      left <= '0;
      cal_ok <= 1'b0;
      cal_fail <= 1'b0;
      no_window <= 1'b0;
      centre_ph <= '0;
      read_lat <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cal_ok <= 1'b0;
          cal_fail <= 1'b0;
          no_window <= 1'b0;
          centre_ph <= '0;
          read_lat <= '0;
          n_steps <= half_rate ? N_W'(MAXN) : N_W'(STEPS_FULL);
          pos <= '0;
          pass_map <= '0;
          state <= S_READ;
        end
        S_READ: if (rd_done) begin
          pass_map[pos] <= rd_pass;
          state <= (pos == last_idx) ? S_EVAL : S_STEP;
        end
        S_STEP: if (step_ack) begin
          pos <= IDX_W'(pos + 1'b1);
          state <= S_READ;
        end
        S_EVAL: begin
          if (!single) begin
            cal_fail <= 1'b1;
            no_window <= (pop == '0);
            state <= S_IDLE;
          end else begin
            centre_ph <= ctr;
            left <= park;
            state <= (park == '0) ? S_LAT : S_PARK;
          end
        end
        S_PARK: if (step_ack) begin
          left <= left - 1'b1;
          if (left == N_W'(1)) state <= S_LAT;
        end
        S_LAT: if (rd_done) begin
          if (rd_pass) begin
            cal_ok <= 1'b1;
            read_lat <= rd_lat;
          end else begin
            cal_fail <= 1'b1;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ok_fail_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_ok && cal_fail));
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> ($stable(cal_ok) && $stable(cal_fail) &&
     $stable(no_window) && $stable(read_lat) && $stable(centre_ph)));
  assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (!cal_ok && !cal_fail && !no_window && read_lat == '0));
  assert_step_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_ack) |=> step_req);
  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> rd_req);
  assert_no_read_in_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && step_req));
  assert_nowin_is_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_window |-> cal_fail);
  assert_fail_lat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fail |-> read_lat == '0);
endmodule

// File: tb/phase_window_cal_test.sv
module phase_window_cal_test;
  localparam int SF = 8;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0, start = 0, half_rate = 0;
  logic step_ack = 0, rd_done = 0, rd_pass = 0;
  logic [LW-1:0] rd_lat = '0;
  logic step_req, rd_req, cal_ok, cal_fail, no_window;
  logic [2:0] step_sel;
  logic [3:0] centre_ph;
  logic [LW-1:0] read_lat;

  int nvec = 0, nfail = 0;

  always #2.5 clk = ~clk;

  phase_window_cal #(.STEPS_FULL(SF), .LAT_W(LW), .PLL_CNT_SEL(3'd4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_rate(half_rate),
    .step_req(step_req), .step_sel(step_sel), .step_ack(step_ack),
    .rd_req(rd_req), .rd_done(rd_done), .rd_pass(rd_pass), .rd_lat(rd_lat),
    .cal_ok(cal_ok), .cal_fail(cal_fail), .no_window(no_window),
    .centre_ph(centre_ph), .read_lat(read_lat));

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nvec++;
    if (!good) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int latf(input int ph);
    return (ph % 7) + 2;
  endfunction

  task automatic sweep(input logic [15:0] pat, input bit hr, input bit poke);
    int n = hr ? 2 * SF : SF;
    int ph = 0, reads = 0, steps = 0, guard = 0, dly = 0;
    int pop = 0, runs = 0, s = 0, ctr = 0;
    bit e_ok, e_nw;
    for (int i = 0; i < n; i++) begin
      int pv = (i == 0) ? n - 1 : i - 1;
      if (pat[i]) pop++;
      if (pat[i] && !pat[pv]) begin runs++; s = i; end
    end
    e_ok = (pop == n) || (pop != 0 && runs == 1);
    e_nw = (pop == 0);
    if (e_ok) ctr = (s + (pop - 1) / 2) % n;
    @(negedge clk); half_rate = hr; start = 1;
    @(negedge clk); start = 0;
    chk(!cal_ok && !cal_fail && !no_window && read_lat == 0, "R9 clear", int'(cal_ok | cal_fail), 0);
    while (!(cal_ok || cal_fail) && guard < 3000) begin
      guard++;
      if (rd_req) begin
        repeat (dly % 3) @(negedge clk);
        rd_done = 1; rd_pass = pat[ph]; rd_lat = LW'(latf(ph));
        if (poke) start = 1;
        reads++; dly++;
        @(negedge clk); rd_done = 0; start = 0;
      end else if (step_req) begin
        repeat ((dly + 1) % 3) @(negedge clk);
        step_ack = 1; steps++; dly++;
        @(negedge clk); step_ack = 0;
        ph = (ph + 1) % n;
      end else @(negedge clk);
    end
    chk(guard < 3000, "R2 sweep completes", guard, 0);
    chk(cal_ok == e_ok, "R3 ok", int'(cal_ok), int'(e_ok));
    chk(cal_fail == !e_ok, "R8 fail", int'(cal_fail), int'(!e_ok));
    chk(no_window == e_nw, "R6 no_window", int'(no_window), int'(e_nw));
    chk(reads == n + (e_ok ? 1 : 0), "R2 read count", reads, n + (e_ok ? 1 : 0));
    if (e_ok) begin
      chk(int'(centre_ph) == ctr, "R3 R4 centre", int'(centre_ph), ctr);
      chk(ph == ctr, "R5 parked phase", ph, ctr);
      chk(steps == n - 1 + (ctr + 1) % n, "R5 step count", steps, n - 1 + (ctr + 1) % n);
      chk(int'(read_lat) == latf(ctr), "R5 latency", int'(read_lat), latf(ctr));
    end else begin
      chk(read_lat == 0 && centre_ph == 0, "R7 zero outputs", int'(read_lat), 0);
      chk(steps == n - 1, "R2 step count", steps, n - 1);
    end
    if (poke) begin
      bit quiet = 1;
      repeat (10) begin
        @(negedge clk);
        if (rd_req || step_req) quiet = 0;
      end
      chk(quiet && cal_ok == e_ok, "R9 start ignored when busy", int'(quiet), 1);
    end
  endtask

  initial begin
    #(5.0 * 195000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cal_ok && !cal_fail && !no_window && !step_req && !rd_req && read_lat == 0 && centre_ph == 0,
        "R1 reset state", int'(cal_ok | cal_fail | step_req | rd_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!step_req && !rd_req && !cal_ok && !cal_fail, "R1 after release", int'(step_req | rd_req), 0);
    chk(step_sel == 3'd4, "R1 step_sel", int'(step_sel), 4);
    for (int p = 0; p < 256; p++) sweep(16'(p), 1'b0, 1'b0);
    for (int s = 0; s < 16; s++)
      for (int l = 1; l <= 16; l++) begin
        logic [15:0] pt = '0;
        for (int k = 0; k < l; k++) pt[(s + k) % 16] = 1'b1;
        if (l < 16 || s == 0) sweep(pt, 1'b1, 1'b0);
      end
    sweep(16'h0000, 1'b1, 1'b0);
    sweep(16'h0101, 1'b1, 1'b0);
    sweep(16'h5555, 1'b1, 1'b0);
    sweep(16'hC003, 1'b1, 1'b0);
    sweep(16'h00F0, 1'b1, 1'b1);
    sweep(16'h0081, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule